// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block holds a 16-bit control word on a simple port bus and arbitrates eight interrupt sources. The low byte of the word is a per-source enable mask; the high byte is a set of plain control outputs (two timer run bits, two timer clock-source selects, a pullup enable, a clock-mode bit, an arm bit and a comparator enable) that feed logic outside this block.

Three of the sources are single-cycle underflow pulses from timers already in the clock domain. The other five come from asynchronous pins. Four single pins each watch one fixed edge direction, alternating rising and falling. An eight-pin group raises one source when any of its pins falls. Every event latches a pending flag whether or not the mask lets it through. A fixed-priority encoder presents the lowest-numbered pending, enabled source as an index together with a request. Service logic clears a flag with an acknowledge pulse that names the index it served.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the control word is 0x0000, all control outputs are 0, `irq_req` is 0, `bus_rdata` is 0 and no source is pending.
- R2: A write strobe at address 0x38 loads the whole word at the next clock edge. Bit 8 drives `t1_src`, bit 9 `t2_src`, bit 10 `t1_en`, bit 11 `t2_en`, bit 12 `pullup_en`, bit 13 `pdm_mode`, bit 14 `arm` and bit 15 `cmp_en`.
- R3: A write strobe at any other address leaves the control word unchanged.
- R4: A read strobe at 0x38 places the whole word on `bus_rdata` one clock after the strobe. A read at any other address returns 0.
- R5: Pending bit 0 is set by `tmr_dac_uf`, bit 1 by `tmr1_uf` and bit 2 by `tmr2_uf`. Bit 3 is set by a rising edge on `d_pins[0]`, bit 4 by a falling edge on any bit of `f_pins`, bit 5 by a falling edge on `d_pins[1]`, bit 6 by a rising edge on `d_pins[2]` and bit 7 by a falling edge on `d_pins[3]`.
- R6: An edge of the opposite direction on a `d_pins` bit, or a rising edge on `f_pins`, sets no pending bit.
- R7: A source whose mask bit (control bit n for source n) is 0 still latches as pending. It raises `irq_req` as soon as its mask bit is written to 1.
- R8: While `irq_req` is 1, `irq_idx` is the lowest-numbered source that is both pending and enabled.
- R9: A one-cycle `irq_ack` clears the pending bit named by `irq_ack_idx` at the next edge. If an event for that same source arrives in the same cycle, the bit stays set.
- R10: `irq_req` is 1 exactly when at least one source is both pending and enabled. A pending bit stays set until it is acknowledged.
- R11: A pin change is seen through a two-stage synchronizer. It sets its pending bit at the third clock edge after the change, never earlier, and only once per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Port address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| tmr_dac_uf | input | 1 | DAC timer underflow pulse (source 0) |
| tmr1_uf | input | 1 | Timer 1 underflow pulse (source 1) |
| tmr2_uf | input | 1 | Timer 2 underflow pulse (source 2) |
| d_pins | input | 4 | Asynchronous single pins feeding sources 3, 5, 6, 7 |
| f_pins | input | 8 | Asynchronous pin group; any falling edge is source 4 |
| irq_ack | input | 1 | Acknowledge pulse |
| irq_ack_idx | input | 3 | Index of the source being acknowledged |
| irq_req | output | 1 | Service request |
| irq_idx | output | 3 | Index of the winning source, valid while irq_req is 1 |
| t1_src | output | 1 | Timer 1 clock select (0 half master clock, 1 oscillator reference) |
| t2_src | output | 1 | Timer 2 clock select |
| t1_en | output | 1 | Timer 1 run |
| t2_en | output | 1 | Timer 2 run |
| pullup_en | output | 1 | Pin group pullup enable |
| pdm_mode | output | 1 | Pulse-density clock mode |
| arm | output | 1 | Arm bit |
| cmp_en | output | 1 | Comparator enable |

## Verification
On every cycle the assertions check that a granted index is both pending and enabled with nothing of higher priority ahead of it. They also check that each source event and each write or read lands in the following cycle, that a flag survives until it is acknowledged, and that writes to other addresses leave the word untouched. Only the bench scenarios show the source-to-bit mapping with its edge polarities, the three-edge pin latency, and that opposite-direction edges are rejected. The same holds for the fact that a masked flag waits and is granted once its mask bit is set, and that an event arriving together with its acknowledge survives.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NUM_SRC = 8;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int REG_W   = 16;

  // bit positions of the control outputs in the upper byte
  localparam int B_T1_SRC = 8;
  localparam int B_T2_SRC = 9;
  localparam int B_T1_EN  = 10;
  localparam int B_T2_EN  = 11;
  localparam int B_PULLUP = 12;
  localparam int B_PDM    = 13;
  localparam int B_ARM    = 14;
  localparam int B_CMP    = 15;

  // polarity of the single pins: 1 = rising edge, 0 = falling edge
  localparam logic [3:0] D_RISE = 4'b0101;

  // lowest-numbered set bit of a source vector
  function automatic logic [IDX_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // all source bits strictly below idx
  function automatic logic [NUM_SRC-1:0] below(input logic [IDX_W-1:0] idx);
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (IDX_W'(i) < idx);
    return m;
  endfunction

  // polarity-selected edge of one sampled pin set
  function automatic logic [3:0] pol_edge(input logic [3:0] cur, input logic [3:0] old);
    return (cur & ~old & D_RISE) | (~cur & old & ~D_RISE);
  endfunction
endpackage

// File: rtl/irq_ctl_sync.sv
module irq_ctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_ctl_edges.sv
module irq_ctl_edges #(
  parameter int PF_W   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      d_pins,
  input  logic [PF_W-1:0] f_pins,
  output logic [3:0]      d_ev,
  output logic            f_ev
);
  import irq_ctl_pkg::*;

  logic [3:0]      d_s, d_old;
  logic [PF_W-1:0] f_s, f_old;

  irq_ctl_sync #(.W(4), .STAGES(STAGES)) u_sync_d (
    .clk(clk), .rst_n(rst_n), .din(d_pins), .dout(d_s));
  irq_ctl_sync #(.W(PF_W), .STAGES(STAGES)) u_sync_f (
    .clk(clk), .rst_n(rst_n), .din(f_pins), .dout(f_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_old <= '0;
      f_old <= '0;
    end else begin
      d_old <= d_s;
      f_old <= f_s;
    end
  end

  assign d_ev = pol_edge(d_s, d_old);
  assign f_ev = |(~f_s & f_old);
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int          ADDR_W    = 8,
  parameter int          DW        = 16,
  parameter logic [7:0]  PORT_ADDR = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     ctrl
);
  logic hit;
  assign hit = (bus_addr == ADDR_W'(PORT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && hit) ctrl <= bus_wdata;
      bus_rdata <= (bus_rd && hit) ? ctrl : '0;
    end
  end
endmodule

// File: rtl/irq_ctl_prio.sv
module irq_ctl_prio (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [irq_ctl_pkg::NUM_SRC-1:0]             src_ev,
  input  logic [irq_ctl_pkg::NUM_SRC-1:0]             mask,
  input  logic                                        ack,
  input  logic [irq_ctl_pkg::IDX_W-1:0]               ack_idx,
  output logic [irq_ctl_pkg::NUM_SRC-1:0]             pend,
  output logic                                        req,
  output logic [irq_ctl_pkg::IDX_W-1:0]               idx
);
  import irq_ctl_pkg::*;

  logic [NUM_SRC-1:0] clr, live;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign clr[i] = ack && (ack_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else if (src_ev[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end

  assign live = pend & mask;
  assign req  = |live;
  assign idx  = first_set(live);
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top #(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] PORT_ADDR   = 8'h38,
  parameter int         PF_W        = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              tmr_dac_uf,
  input  logic              tmr1_uf,
  input  logic              tmr2_uf,
  input  logic [3:0]        d_pins,
  input  logic [PF_W-1:0]   f_pins,
  input  logic              irq_ack,
  input  logic [2:0]        irq_ack_idx,
  output logic              irq_req,
  output logic [2:0]        irq_idx,
  output logic              t1_src,
  output logic              t2_src,
  output logic              t1_en,
  output logic              t2_en,
  output logic              pullup_en,
  output logic              pdm_mode,
  output logic              arm,
  output logic              cmp_en
);
  import irq_ctl_pkg::*;

  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0] src_ev, pend_q;
  logic [3:0]         d_ev;
  logic               f_ev;

  irq_ctl_regs #(.ADDR_W(ADDR_W), .DW(REG_W), .PORT_ADDR(PORT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl_q));

  irq_ctl_edges #(.PF_W(PF_W), .STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .d_pins(d_pins), .f_pins(f_pins),
    .d_ev(d_ev), .f_ev(f_ev));

  // source order sets priority: bit 0 wins
  assign src_ev = {d_ev[3], d_ev[2], d_ev[1], f_ev, d_ev[0], tmr2_uf, tmr1_uf, tmr_dac_uf};

  irq_ctl_prio u_prio (
    .clk(clk), .rst_n(rst_n), .src_ev(src_ev), .mask(ctrl_q[NUM_SRC-1:0]),
    .ack(irq_ack), .ack_idx(irq_ack_idx), .pend(pend_q),
    .req(irq_req), .idx(irq_idx));

  assign t1_src    = ctrl_q[B_T1_SRC];
  assign t2_src    = ctrl_q[B_T2_SRC];
  assign t1_en     = ctrl_q[B_T1_EN];
  assign t2_en     = ctrl_q[B_T2_EN];
  assign pullup_en = ctrl_q[B_PULLUP];
  assign pdm_mode  = ctrl_q[B_PDM];
  assign arm       = ctrl_q[B_ARM];
  assign cmp_en    = ctrl_q[B_CMP];
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [15:0] ctrl_q,
  input logic [7:0]  src_ev,
  input logic [7:0]  pend_q,
  input logic        irq_ack,
  input logic [2:0]  irq_ack_idx,
  input logic        irq_req,
  input logic [2:0]  irq_idx
);
  import irq_ctl_pkg::*;

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h38) |=> ctrl_q == $past(bus_wdata));

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 8'h38) |=> $stable(ctrl_q));

  p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h38) |=> bus_rdata == $past(ctrl_q));

  p_event_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ev != 8'h00) |=> (pend_q & $past(src_ev)) == $past(src_ev));

  p_grant_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[irq_idx] && ctrl_q[irq_idx]));

  p_grant_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend_q & ctrl_q[7:0] & below(irq_idx)) == 8'h00));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !src_ev[irq_ack_idx]) |=> !pend_q[$past(irq_ack_idx)]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> (pend_q & $past(pend_q)) == $past(pend_q));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ctrl_q[7:0]) == 8'h00) |-> !irq_req);
endmodule

bind irq_ctl_top irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ctrl_q(ctrl_q), .src_ev(src_ev), .pend_q(pend_q), .irq_ack(irq_ack),
  .irq_ack_idx(irq_ack_idx), .irq_req(irq_req), .irq_idx(irq_idx));

// File: tb/irq_ctl_top_bench.sv
module irq_ctl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tmr_dac_uf = 1'b0, tmr1_uf = 1'b0, tmr2_uf = 1'b0;
  logic [3:0]  d_pins = 4'h0;
  logic [7:0]  f_pins = 8'hFF;
  logic        irq_ack = 1'b0;
  logic [2:0]  irq_ack_idx = '0;
  logic        irq_req;
  logic [2:0]  irq_idx;
  logic        t1_src, t2_src, t1_en, t2_en, pullup_en, pdm_mode, arm, cmp_en;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_ctl_top u_irq_ctl_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_dac_uf(tmr_dac_uf), .tmr1_uf(tmr1_uf), .tmr2_uf(tmr2_uf),
    .d_pins(d_pins), .f_pins(f_pins), .irq_ack(irq_ack),
    .irq_ack_idx(irq_ack_idx), .irq_req(irq_req), .irq_idx(irq_idx),
    .t1_src(t1_src), .t2_src(t2_src), .t1_en(t1_en), .t2_en(t2_en),
    .pullup_en(pullup_en), .pdm_mode(pdm_mode), .arm(arm), .cmp_en(cmp_en));

  // {address, write data, expected word afterwards}
  localparam logic [39:0] VEC [6] = '{
    {8'h38, 16'hA5C3, 16'hA5C3},
    {8'h37, 16'hFFFF, 16'hA5C3},
    {8'h38, 16'h0F00, 16'h0F00},
    {8'h39, 16'h1234, 16'h0F00},
    {8'h38, 16'hF0FF, 16'hF0FF},
    {8'h00, 16'h0000, 16'hF0FF}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    step(1);
    bus_rd = 1'b0;
  endtask

  task automatic ack(input logic [2:0] i);
    irq_ack = 1'b1; irq_ack_idx = i;
    step(1);
    irq_ack = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {cmp_en, arm, pdm_mode, pullup_en, t2_en, t1_en, t2_src, t1_src};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset state
    chk("R1 ctrl outputs", 32'(outs()), 32'h0);
    chk("R1 req", 32'(irq_req), 32'h0);
    chk("R1 rdata", 32'(bus_rdata), 32'h0);
    rst_n = 1'b1;
    step(3);
    rd(8'h38);
    chk("R1 word after reset", 32'(bus_rdata), 32'h0);
    chk("R1 nothing pending", 32'(irq_req), 32'h0);

    // R2 R3 R4: register vector table
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][39:32], VEC[k][31:16]);
      chk("R2/R3 control outputs", 32'(outs()), 32'(VEC[k][15:8]));
      rd(8'h38);
      chk("R4 readback", 32'(bus_rdata), 32'(VEC[k][15:0]));
    end
    rd(8'h3A);
    chk("R4 other address reads zero", 32'(bus_rdata), 32'h0);

    wr(8'h38, 16'h00FF);
    // R5: timer sources
    tmr_dac_uf = 1'b1; step(1); tmr_dac_uf = 1'b0;
    chk("R5 dac req", 32'(irq_req), 32'h1);
    chk("R5 dac idx", 32'(irq_idx), 32'h0);
    ack(3'd0);
    chk("R9 ack clears", 32'(irq_req), 32'h0);

    // R11 R5: rising edge on d_pins[0] -> source 3, three edges
    d_pins[0] = 1'b1;
    step(2);
    chk("R11 not before third edge", 32'(irq_req), 32'h0);
    step(1);
    chk("R11 set on third edge", 32'(irq_req), 32'h1);
    chk("R5 pin rise idx", 32'(irq_idx), 32'h3);
    ack(3'd3);
    step(3);
    chk("R11 one event per edge", 32'(irq_req), 32'h0);

    // R6: wrong-direction edges
    d_pins[0] = 1'b0; d_pins[1] = 1'b1; d_pins[3] = 1'b1;
    step(5);
    chk("R6 wrong polarity ignored", 32'(irq_req), 32'h0);
    f_pins = 8'h00; step(4); f_pins = 8'hFF; step(4); ack(3'd4);
    f_pins = 8'hFF; step(4);
    chk("R6 rising on group ignored", 32'(irq_req), 32'h0);

    // R5: group falling edge on one pin -> source 4
    f_pins[5] = 1'b0; step(4);
    chk("R5 group fall idx", 32'(irq_idx), 32'h4);
    ack(3'd4);
    // R5: falling d_pins[1] -> source 5
    d_pins[1] = 1'b0; step(4);
    chk("R5 pin3 fall idx", 32'(irq_idx), 32'h5);
    ack(3'd5);
    // R5: falling d_pins[3] -> source 7
    d_pins[3] = 1'b0; step(4);
    chk("R5 pin5 fall idx", 32'(irq_idx), 32'h7);
    ack(3'd7);

    // R8: priority between source 2 and source 6
    d_pins[2] = 1'b1; step(2);
    tmr2_uf = 1'b1; step(1); tmr2_uf = 1'b0;
    chk("R8 higher wins", 32'(irq_idx), 32'h2);
    ack(3'd2);
    chk("R8 next in line", 32'(irq_idx), 32'h6);
    ack(3'd6);
    chk("R10 all served", 32'(irq_req), 32'h0);

    // R7: masked source latches and fires on unmask
    wr(8'h38, 16'h0000);
    tmr1_uf = 1'b1; step(1); tmr1_uf = 1'b0;
    step(2);
    chk("R7 masked no req", 32'(irq_req), 32'h0);
    wr(8'h38, 16'h0002);
    chk("R7 req after unmask", 32'(irq_req), 32'h1);
    chk("R7 idx", 32'(irq_idx), 32'h1);

    // R9: event in the same cycle as its acknowledge survives
    irq_ack = 1'b1; irq_ack_idx = 3'd1; tmr1_uf = 1'b1;
    step(1);
    irq_ack = 1'b0; tmr1_uf = 1'b0;
    chk("R9 event wins over ack", 32'(irq_req), 32'h1);
    ack(3'd5);
    chk("R9 other index leaves flag", 32'(irq_req), 32'h1);
    ack(3'd1);
    chk("R9 cleared", 32'(irq_req), 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule